// File: doc/BRIEF.md
# Decode-Stage Operand Bypass Selector

This block sits in the decode stage of a five-stage integer pipeline whose memory stage passes results through. For each of the two source operands of the instruction in decode, it chooses where the operand value should come from: the register file, the result held in the register between execute and memory, or the result held in the register between memory and writeback. The selection is purely combinational. It compares the two source indices with the destination index, the register-write flag and the load flag of the instructions now in execute and in memory.

An instruction that writes no register, that targets register 0, or that is a load never supplies a bypassed value. When both younger stages match the same source, the execute-stage result wins because it is the newer value. When a source depends on a load still in execute, no bypass can supply the value in time, so the block raises a stall request. Holding the pipeline, and the data multiplexers driven by the selects, belong to the surrounding pipeline logic.

Top module: `opnd_bypass_sel`

## Requirements
- R1: A source whose index matches no eligible producer gets select code 2'b00, which means register file.
- R2: A source equal to a nonzero execute-stage destination gets select code 2'b01, which means execute result, when that instruction writes a register and is not a load.
- R3: A source equal to a nonzero memory-stage destination gets select code 2'b10, which means memory result, when that instruction writes a register and is not a load, and execute does not qualify under R2.
- R4: When both stages qualify for the same source, the select is 2'b01, so the execute stage wins.
- R5: A destination index of 0 never causes a bypass or a stall, even when a source index is 0.
- R6: A stage whose register-write flag is clear never causes a bypass or a stall.
- R7: A load, in either stage, is never chosen as a bypass source. A source that matches only a load in memory reads the register file.
- R8: `stall_req` is 1 exactly when some source matches a nonzero execute-stage destination whose instruction writes a register and is a load. For that source, the select ignores execute and follows R3 or R1.
- R9: The two sources are evaluated independently, so one may select execute while the other selects memory. Select code 2'b11 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rs_a | input | IDX_W | First source register index in decode |
| rs_b | input | IDX_W | Second source register index in decode |
| ex_rd | input | IDX_W | Destination index of the execute-stage instruction |
| ex_wen | input | 1 | Execute-stage instruction writes a register |
| ex_load | input | 1 | Execute-stage instruction is a load |
| mem_rd | input | IDX_W | Destination index of the memory-stage instruction |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| mem_load | input | 1 | Memory-stage instruction is a load |
| sel_a | output | 2 | Source select for first operand (00 file, 01 execute, 10 memory) |
| sel_b | output | 2 | Source select for second operand (same coding) |
| stall_req | output | 1 | Request to hold decode because a load in execute feeds a source |

## Verification
Two functions often fall in the same cycle. The first is the bypass of one operand, and the second is either the stall request raised by the other operand or the priority choice when both stages match. The random stimulus draws indices from a small range so that matches among rs_a, rs_b, ex_rd and mem_rd are common, and it toggles the write and load flags freely. Directed vectors then set up the mixed cases, where one source comes from execute and the other from memory, or one source needs a stall while the other is bypassed. Each output is judged against a bench model written from the requirements, so both selects and the stall request are checked together in every vector.

// File: rtl/opnd_bypass_sel.sv
module opnd_bypass_sel #(
  parameter int IDX_W = 5
) (
  input  logic [IDX_W-1:0] rs_a,
  input  logic [IDX_W-1:0] rs_b,
  input  logic [IDX_W-1:0] ex_rd,
  input  logic             ex_wen,
  input  logic             ex_load,
  input  logic [IDX_W-1:0] mem_rd,
  input  logic             mem_wen,
  input  logic             mem_load,
  output logic [1:0]       sel_a,
  output logic [1:0]       sel_b,
  output logic             stall_req
);
  localparam logic [1:0] SEL_FILE = 2'b00;
  localparam logic [1:0] SEL_EX   = 2'b01;
  localparam logic [1:0] SEL_MEM  = 2'b10;

  logic ex_live, mem_live;
  assign ex_live  = ex_wen  && (ex_rd  != '0);
  assign mem_live = mem_wen && (mem_rd != '0);

  logic [IDX_W-1:0] src [2];
  logic [1:0]       sel [2];
  logic [1:0]       hold;

  assign src[0] = rs_a;
  assign src[1] = rs_b;

  for (genvar i = 0; i < 2; i++) begin : g_opnd
    logic hit_ex, hit_mem;
    assign hit_ex  = ex_live  && (src[i] == ex_rd);
    assign hit_mem = mem_live && (src[i] == mem_rd);
    assign hold[i] = hit_ex && ex_load;
    assign sel[i]  = (hit_ex && !ex_load)   ? SEL_EX  :
                     (hit_mem && !mem_load) ? SEL_MEM : SEL_FILE;
  end

  assign sel_a     = sel[0];
  assign sel_b     = sel[1];
  assign stall_req = |hold;
endmodule

module opnd_bypass_sel_chk #(
  parameter int IDX_W = 5
) (
  input logic [IDX_W-1:0] rs_a,
  input logic [IDX_W-1:0] rs_b,
  input logic [IDX_W-1:0] ex_rd,
  input logic             ex_wen,
  input logic             ex_load,
  input logic [IDX_W-1:0] mem_rd,
  input logic             mem_wen,
  input logic             mem_load,
  input logic [1:0]       sel_a,
  input logic [1:0]       sel_b,
  input logic             stall_req
);
  always_comb begin
    // R9
    sel_code_legal_chk: assert (sel_a != 2'b11 && sel_b != 2'b11);
    // R6
    no_wen_no_fwd_chk: assert (ex_wen || mem_wen || (sel_a == 2'b00 && sel_b == 2'b00 && !stall_req));
    // R5
    zero_dst_quiet_chk: assert (!(ex_rd == '0 && mem_rd == '0) || (sel_a == 2'b00 && sel_b == 2'b00 && !stall_req));
    // R7
    load_never_src_chk: assert (!(ex_load && mem_load) || (sel_a == 2'b00 && sel_b == 2'b00));
    // R8
    stall_needs_ex_load_chk: assert (!stall_req || (ex_load && ex_wen && ex_rd != '0));
    // R4
    ex_wins_chk: assert (!(ex_wen && !ex_load && ex_rd != '0 && rs_a == ex_rd) || sel_a == 2'b01);
  end
endmodule

bind opnd_bypass_sel opnd_bypass_sel_chk #(.IDX_W(IDX_W)) i_chk (.*);

// File: tb/test_opnd_bypass_sel.sv
module test_opnd_bypass_sel;
  localparam int IDX_W = 5;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [IDX_W-1:0] rs_a, rs_b, ex_rd, mem_rd;
  logic ex_wen, ex_load, mem_wen, mem_load;
  logic [1:0] sel_a, sel_b;
  logic stall_req;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  opnd_bypass_sel #(.IDX_W(IDX_W)) i_opnd_bypass_sel (.*);

  function automatic logic [1:0] ref_sel(input logic [IDX_W-1:0] s);
    if (ex_wen && ex_rd != 0 && !ex_load && s == ex_rd) return 2'b01;
    if (mem_wen && mem_rd != 0 && !mem_load && s == mem_rd) return 2'b10;
    return 2'b00;
  endfunction

  function automatic logic ref_stall();
    return ex_wen && ex_load && ex_rd != 0 && (rs_a == ex_rd || rs_b == ex_rd);
  endfunction

  task automatic apply(input logic [IDX_W-1:0] a, b, er, input logic ew, el,
                       input logic [IDX_W-1:0] mr, input logic mw, ml, input string tag);
    @(negedge clk);
    rs_a = a; rs_b = b; ex_rd = er; ex_wen = ew; ex_load = el;
    mem_rd = mr; mem_wen = mw; mem_load = ml;
    #1;
    n_run++;
    if (sel_a !== ref_sel(a) || sel_b !== ref_sel(b) || stall_req !== ref_stall()) begin
      n_fail++;
      $display("FAIL %s: got a=%b b=%b st=%b exp a=%b b=%b st=%b", tag,
               sel_a, sel_b, stall_req, ref_sel(a), ref_sel(b), ref_stall());
    end
  endtask

  task automatic expect_exact(input logic [1:0] ea, eb, input logic es, input string tag);
    n_run++;
    if (sel_a !== ea || sel_b !== eb || stall_req !== es) begin
      n_fail++;
      $display("FAIL %s: got a=%b b=%b st=%b exp a=%b b=%b st=%b", tag,
               sel_a, sel_b, stall_req, ea, eb, es);
    end
  endtask

  initial begin
    process::self().srandom(32'd4242);
    apply(0, 0, 0, 0, 0, 0, 0, 0, "R1 idle");
    expect_exact(2'b00, 2'b00, 1'b0, "R1 idle exact");
    apply(3, 4, 3, 1, 0, 9, 1, 0, "R2 ex hit a");
    expect_exact(2'b01, 2'b00, 1'b0, "R2 exact");
    apply(3, 9, 7, 1, 0, 9, 1, 0, "R3 mem hit b");
    expect_exact(2'b00, 2'b10, 1'b0, "R3 exact");
    apply(6, 6, 6, 1, 0, 6, 1, 0, "R4 both stages");
    expect_exact(2'b01, 2'b01, 1'b0, "R4 exact");
    apply(0, 0, 0, 1, 0, 0, 1, 0, "R5 zero dst");
    expect_exact(2'b00, 2'b00, 1'b0, "R5 exact");
    apply(0, 0, 0, 1, 1, 0, 1, 1, "R5 zero dst load");
    expect_exact(2'b00, 2'b00, 1'b0, "R5 exact load");
    apply(5, 8, 5, 0, 1, 8, 0, 0, "R6 no write");
    expect_exact(2'b00, 2'b00, 1'b0, "R6 exact");
    apply(8, 2, 1, 1, 0, 8, 1, 1, "R7 mem load");
    expect_exact(2'b00, 2'b00, 1'b0, "R7 exact");
    apply(4, 4, 4, 1, 1, 4, 1, 0, "R8 stall with mem fallback");
    expect_exact(2'b10, 2'b10, 1'b1, "R8 exact fallback");
    apply(4, 2, 4, 1, 1, 2, 1, 0, "R8 R9 stall a bypass b");
    expect_exact(2'b00, 2'b10, 1'b1, "R8 R9 exact");
    apply(11, 12, 11, 1, 0, 12, 1, 0, "R9 mixed sources");
    expect_exact(2'b01, 2'b10, 1'b0, "R9 exact");
    apply(31, 31, 31, 1, 0, 31, 1, 0, "R4 top index");
    expect_exact(2'b01, 2'b01, 1'b0, "R4 top exact");
    for (int k = 0; k < 4000; k++) begin
      apply(IDX_W'($urandom_range(0, 3)), IDX_W'($urandom_range(0, 3)),
            IDX_W'($urandom_range(0, 3)), 1'($urandom), 1'($urandom),
            IDX_W'($urandom_range(0, 3)), 1'($urandom), 1'($urandom), "R1-9 random");
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout exp completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule